// File: doc/BRIEF.md
# Repeating Time-of-Day Alarm

This block holds an alarm setting made of four BCD bytes (seconds, minutes, hours, day of month). It watches the current time supplied by a separate clock block and raises a one-cycle interrupt pulse when the alarm matches. Bit 7 of each alarm byte is a "don't care" flag. The pattern of these flags across the four bytes picks one of five repeat periods: monthly, daily, hourly, per minute or per second.

Software-side logic writes the alarm bytes one at a time, using a 2-bit field select. A write whose value is out of range for its field is dropped, and the stored byte keeps its old value. Any stored byte can be read back combinationally through a separate read select.

The clock block supplies a one-cycle strobe at each seconds boundary. The compare is taken only on that strobe, so a matching second yields exactly one pulse. A single enable input gates the pulse.

Top module: `alarm_unit`

## Requirements
- R1: A write to the seconds field (select 0) or the minutes field (select 1) is stored only if the value of its low 7 bits, read as BCD (tens nibble × 10 + units nibble), is at most 59. Otherwise the stored byte is unchanged.
- R2: A write to the hours field (select 2) is stored only if the BCD value of its low 6 bits is at most 23. Otherwise the stored byte is unchanged.
- R3: A write to the date field (select 3) is stored only if the BCD value of its low 5 bits is non-zero. Otherwise the stored byte is unchanged.
- R4: An accepted write stores all 8 bits, including the bit 7 flag and the bits outside the compared field. `rd_data` shows the byte picked by `rd_sel` in the same cycle.
- R5: After reset all four alarm bytes read 0x00 and `irq` is low.
- R6: With no bit 7 flag set, the alarm fires only when the seconds, minutes, hours and date all match the current time (monthly repeat).
- R7: With only the date flag set, the alarm fires when seconds, minutes and hours match (daily repeat).
- R8: With the date and hours flags set and the others clear, the alarm fires when seconds and minutes match (hourly repeat).
- R9: With the date, hours and minutes flags set and seconds clear, the alarm fires when the seconds match (per-minute repeat).
- R10: Any other flag pattern makes the alarm fire on every seconds strobe.
- R11: `irq` is high for exactly the one cycle after a cycle in which `sec_tick` was high and the alarm matched. `irq` never rises without a strobe.
- R12: When `irq_en` is low in the strobe cycle, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one alarm byte |
| wr_sel | input | 2 | Field select: 0 seconds, 1 minutes, 2 hours, 3 date |
| wr_data | input | 8 | Byte to write; bit 7 is the don't-care flag |
| rd_sel | input | 2 | Field select for read-back |
| rd_data | output | 8 | Stored byte of the selected field |
| irq_en | input | 1 | Interrupt enable |
| sec_tick | input | 1 | One-cycle strobe at each new second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
The bench uses a single mismatch in one field per repeat mode. A decoder that compared too many fields would miss the daily and hourly hits, and one that compared too few would fire on the mismatches. It writes boundary values such as 0x59 against 0x60, 0x5A (which decodes to 60), 0x23 against 0x24, and date bytes whose low five bits are zero but whose flag is set. Each of these catches a range check on the wrong bit mask or an off-by-one limit. It also drives a matching time without a strobe and a strobe with the enable low. It watches that the pulse lasts exactly one cycle, which catches an interrupt that is level-sensitive or left sticky.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DATA_W = 8;
  localparam int NFIELD = 4;
  localparam int SEL_W  = $clog2(NFIELD);
  localparam int FLAG_BIT = DATA_W - 1;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HOUR = 2'd2,
    FLD_DATE = 2'd3
  } fld_e;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MIN,
    RPT_SEC
  } rpt_e;

  // bits of each field that carry the BCD value
  function automatic logic [DATA_W-1:0] fld_mask(input fld_e f);
    case (f)
      FLD_SEC, FLD_MIN: fld_mask = 8'h7F;
      FLD_HOUR:         fld_mask = 8'h3F;
      default:          fld_mask = 8'h1F;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] bcd_to_bin(input logic [DATA_W-1:0] b);
    bcd_to_bin = DATA_W'(b[7:4]) * DATA_W'(10) + DATA_W'(b[3:0]);
  endfunction

  function automatic logic fld_ok(input fld_e f, input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] n;
    n = bcd_to_bin(v & fld_mask(f));
    case (f)
      FLD_SEC, FLD_MIN: fld_ok = (n <= 8'd59);
      FLD_HOUR:         fld_ok = (n <= 8'd23);
      default:          fld_ok = (n != 8'd0);
    endcase
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NF = NFIELD
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [DW-1:0]            wr_data,
  output logic [NF-1:0][DW-1:0]    alm_o
);
  for (genvar i = 0; i < NF; i++) begin : g_fld
    logic [DW-1:0] q;
    logic          ld;

    always_comb begin
      ld = wr_en && (wr_sel == SEL_W'(i)) && fld_ok(fld_e'(i), wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ld) begin
        q <= wr_data;
      end
    end

    assign alm_o[i] = q;
  end
endmodule

// File: rtl/alarm_mode_dec.sv
module alarm_mode_dec
  import alarm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NF = NFIELD
) (
  input  logic [NF-1:0][DW-1:0] alm_i,
  output rpt_e                  mode_o,
  output logic [NF-1:0]         cmp_en_o
);
  logic [NF-1:0] flags;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    assign flags[i] = alm_i[i][DW-1];
  end

  // flags ordered {date, hour, min, sec}
  always_comb begin
    case (flags)
      4'b0000: mode_o = RPT_MONTH;
      4'b1000: mode_o = RPT_DAY;
      4'b1100: mode_o = RPT_HOUR;
      4'b1110: mode_o = RPT_MIN;
      default: mode_o = RPT_SEC;
    endcase
  end

  always_comb begin
    cmp_en_o           = '0;
    cmp_en_o[FLD_SEC]  = (mode_o != RPT_SEC);
    cmp_en_o[FLD_MIN]  = (mode_o == RPT_MONTH) || (mode_o == RPT_DAY) || (mode_o == RPT_HOUR);
    cmp_en_o[FLD_HOUR] = (mode_o == RPT_MONTH) || (mode_o == RPT_DAY);
    cmp_en_o[FLD_DATE] = (mode_o == RPT_MONTH);
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NF = NFIELD
) (
  input  logic [NF-1:0][DW-1:0] alm_i,
  input  logic [NF-1:0][DW-1:0] now_i,
  input  logic [NF-1:0]         cmp_en_i,
  output logic                  match_o
);
  logic [NF-1:0] hit;

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    logic [DW-1:0] m;
    assign m      = fld_mask(fld_e'(i));
    assign hit[i] = !cmp_en_i[i] || ((alm_i[i] & m) == (now_i[i] & m));
  end

  assign match_o = &hit;
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              irq_en,
  input  logic              sec_tick,
  input  logic [DATA_W-1:0] now_sec,
  input  logic [DATA_W-1:0] now_min,
  input  logic [DATA_W-1:0] now_hour,
  input  logic [DATA_W-1:0] now_date,
  output logic              irq
);
  logic [NFIELD-1:0][DATA_W-1:0] alm_q;
  logic [NFIELD-1:0][DATA_W-1:0] now_w;
  logic [NFIELD-1:0]             cmp_en;
  rpt_e                          mode;
  logic                          match;
  logic                          irq_d;
  logic                          irq_q;

  assign now_w = {now_date, now_hour, now_min, now_sec};

  alarm_regs #(.DW(DATA_W), .NF(NFIELD)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .alm_o   (alm_q)
  );

  alarm_mode_dec #(.DW(DATA_W), .NF(NFIELD)) dec_i (
    .alm_i    (alm_q),
    .mode_o   (mode),
    .cmp_en_o (cmp_en)
  );

  alarm_match #(.DW(DATA_W), .NF(NFIELD)) cmp_i (
    .alm_i    (alm_q),
    .now_i    (now_w),
    .cmp_en_i (cmp_en),
    .match_o  (match)
  );

  always_comb begin
    irq_d = sec_tick && irq_en && match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq     = irq_q;
  assign rd_data = alm_q[rd_sel];
endmodule

// File: rtl/alarm_unit_chk.sv
module alarm_unit_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [1:0]      wr_sel,
  input logic [7:0]      wr_data,
  input logic            irq_en,
  input logic            sec_tick,
  input logic            irq,
  input logic [3:0][7:0] alm
);
  function automatic int unsigned dec(input logic [7:0] b);
    dec = int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  // R1
  sec_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && dec(wr_data & 8'h7F) > 59) |=> $stable(alm[0]));

  // R2
  hour_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && dec(wr_data & 8'h3F) > 23) |=> $stable(alm[2]));

  // R3
  date_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3 && (wr_data & 8'h1F) == 8'h00) |=> $stable(alm[3]));

  // R4
  date_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3 && dec(wr_data & 8'h1F) != 0) |=> (alm[3] == $past(wr_data)));

  // R10
  every_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && irq_en && alm[0][7]) |=> irq);

  // R11
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(sec_tick));

  // R12
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en));
endmodule

bind alarm_unit alarm_unit_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .irq_en   (irq_en),
  .sec_tick (sec_tick),
  .irq      (irq),
  .alm      (alm_q)
);

// File: tb/alarm_unit_tb_top.sv
module alarm_unit_tb_top;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [1:0] rd_sel;
  logic [7:0] rd_data;
  logic       irq_en;
  logic       sec_tick;
  logic [7:0] now_sec, now_min, now_hour, now_date;
  logic       irq;

  int nchk = 0;
  int nbad = 0;

  alarm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_en(irq_en), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {alarm s,m,h,d, now s,m,h,d, expected irq, group}
  // group: 0 monthly, 1 daily, 2 hourly, 3 per minute, 4 per second
  localparam logic [67:0] VECS [12] = '{
    {8'h30, 8'h45, 8'h12, 8'h15, 8'h30, 8'h45, 8'h12, 8'h15, 1'b1, 3'd0},
    {8'h30, 8'h45, 8'h12, 8'h15, 8'h30, 8'h45, 8'h12, 8'h16, 1'b0, 3'd0},
    {8'h30, 8'h45, 8'h12, 8'h15, 8'h31, 8'h45, 8'h12, 8'h15, 1'b0, 3'd0},
    {8'h30, 8'h45, 8'h12, 8'h95, 8'h30, 8'h45, 8'h12, 8'h20, 1'b1, 3'd1},
    {8'h30, 8'h45, 8'h12, 8'h95, 8'h30, 8'h45, 8'h13, 8'h20, 1'b0, 3'd1},
    {8'h30, 8'h45, 8'h92, 8'h95, 8'h30, 8'h45, 8'h07, 8'h03, 1'b1, 3'd2},
    {8'h30, 8'h45, 8'h92, 8'h95, 8'h30, 8'h46, 8'h07, 8'h03, 1'b0, 3'd2},
    {8'h30, 8'hC5, 8'h92, 8'h95, 8'h30, 8'h11, 8'h05, 8'h09, 1'b1, 3'd3},
    {8'h30, 8'hC5, 8'h92, 8'h95, 8'h31, 8'h11, 8'h05, 8'h09, 1'b0, 3'd3},
    {8'hB0, 8'h45, 8'h12, 8'h15, 8'h01, 8'h02, 8'h03, 8'h04, 1'b1, 3'd4},
    {8'h30, 8'hC5, 8'h12, 8'h95, 8'h07, 8'h08, 8'h09, 8'h10, 1'b1, 3'd4},
    {8'hB0, 8'hC5, 8'h92, 8'h95, 8'h59, 8'h59, 8'h23, 8'h31, 1'b1, 3'd4}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    rd_sel = sel;
    #1;
    d = rd_data;
  endtask

  // one strobe; returns irq in the cycle after, and irq one cycle later
  task automatic tick(output logic first, output logic second);
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    first = irq;
    @(negedge clk);
    second = irq;
  endtask

  task automatic set_now(input logic [7:0] s, m, h, d);
    now_sec = s; now_min = m; now_hour = h; now_date = d;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic p1, p2;
    string tag;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    irq_en = 1'b1; sec_tick = 1'b0;
    set_now(8'h00, 8'h00, 8'h00, 8'h01);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      check("R5 reset byte", v, 8'h00);
    end
    check("R5 reset irq", {7'd0, irq}, 8'h00);

    // table walk over repeat modes
    for (int k = 0; k < 12; k++) begin
      logic [67:0] e;
      e = VECS[k];
      wr(2'd0, e[67:60]); wr(2'd1, e[59:52]); wr(2'd2, e[51:44]); wr(2'd3, e[43:36]);
      set_now(e[35:28], e[27:20], e[19:12], e[11:4]);
      case (e[2:0])
        3'd0: tag = "R6 monthly";
        3'd1: tag = "R7 daily";
        3'd2: tag = "R8 hourly";
        3'd3: tag = "R9 minute";
        default: tag = "R10 every second";
      endcase
      tick(p1, p2);
      check(tag, {7'd0, p1}, {7'd0, e[3]});
      check("R11 pulse ends", {7'd0, p2}, 8'h00);
    end

    // R1 seconds/minutes range
    wr(2'd0, 8'h59); rd(2'd0, v); check("R1 sec 59 accepted", v, 8'h59);
    wr(2'd0, 8'h60); rd(2'd0, v); check("R1 sec 60 rejected", v, 8'h59);
    wr(2'd1, 8'h00); rd(2'd1, v); check("R1 min 00 accepted", v, 8'h00);
    wr(2'd1, 8'h5A); rd(2'd1, v); check("R1 min 5A rejected", v, 8'h00);

    // R2 hours range
    wr(2'd2, 8'h23); rd(2'd2, v); check("R2 hour 23 accepted", v, 8'h23);
    wr(2'd2, 8'h24); rd(2'd2, v); check("R2 hour 24 rejected", v, 8'h23);

    // R3 date non-zero
    wr(2'd3, 8'h31); rd(2'd3, v); check("R3 date 31 accepted", v, 8'h31);
    wr(2'd3, 8'h00); rd(2'd3, v); check("R3 date 00 rejected", v, 8'h31);
    wr(2'd3, 8'h80); rd(2'd3, v); check("R3 flagged zero rejected", v, 8'h31);

    // R4 full byte kept
    wr(2'd0, 8'hD9); rd(2'd0, v); check("R4 sec readback", v, 8'hD9);
    wr(2'd2, 8'hE3); rd(2'd2, v); check("R4 hour readback", v, 8'hE3);
    wr(2'd3, 8'hE1); rd(2'd3, v); check("R4 date readback", v, 8'hE1);

    // monthly setup for strobe/enable tests
    wr(2'd0, 8'h10); wr(2'd1, 8'h20); wr(2'd2, 8'h08); wr(2'd3, 8'h05);
    set_now(8'h10, 8'h20, 8'h08, 8'h05);

    // R11 no strobe, no pulse
    p1 = 1'b0;
    repeat (5) begin
      @(negedge clk);
      p1 = p1 | irq;
    end
    check("R11 no strobe no pulse", {7'd0, p1}, 8'h00);

    // R12 enable low
    irq_en = 1'b0;
    tick(p1, p2);
    check("R12 disabled", {7'd0, p1}, 8'h00);
    irq_en = 1'b1;
    tick(p1, p2);
    check("R12 re-enabled", {7'd0, p1}, 8'h01);
    check("R11 single cycle", {7'd0, p2}, 8'h00);

    // R5 reset mid-run clears state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(2'd3, v); check("R5 date after reset", v, 8'h00);

    finish_run();
  end
endmodule